// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It supports a small fixed subset of a classic three-format load/store instruction set: word load and store, add, subtract, bitwise AND and OR, signed set-on-less-than, branch-if-equal and an absolute jump. A program counter, a 32-entry register file, an ALU, and word-wide instruction and data arrays are all inside the block.

Decoding is done in two levels. A main decoder sees only the 6-bit opcode. It produces the datapath steering signals and a 2-bit operation class. A second, smaller decoder combines that class with the 6-bit funct field and produces a 4-bit ALU selector. Before reset is released, a simple word-write port fills the two arrays. The block's outputs show the current PC and every architectural register write as it is committed.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst_n` is low, the PC is 0 and all registers hold 0. After release, the first instruction fetched is word 0, and any register that has not been written reads as 0.
- R2: An R-type instruction (opcode 0) with funct 32 (add), 34 (sub), 36 (and) or 37 (or) writes the result of R[rs] op R[rt] into R[rd]. Field positions: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0].
- R3: Set-on-less-than (opcode 0, funct 42) writes 1 into R[rd] when R[rs] is less than R[rt] as signed two's-complement values, and writes 0 otherwise.
- R4: Load (opcode 35) writes R[rt] with the data word at byte address R[rs] plus imm[15:0] sign-extended. Address bits [1:0] are ignored and the word index wraps modulo the array depth.
- R5: Store (opcode 43) writes R[rt] into the data word at R[rs] plus the sign-extended imm. It writes no register, and a later load returns the stored value.
- R6: Branch (opcode 4) sets the PC to PC+4+(sext(imm)×4) when R[rs] equals R[rt], and to PC+4 otherwise. It writes no register and no memory. Negative offsets are allowed.
- R7: Jump (opcode 2) sets the PC to {PC[31:28], addr[25:0], 2'b00} and writes nothing.
- R8: Register 0 always reads as zero. An instruction that targets it produces no register-write strobe.
- R9: Any other opcode, and any R-type funct outside the five listed, writes nothing and advances the PC by 4.
- R10: The main decoder's class is 00 for loads and stores (forces add), 01 for branch (forces subtract) and 10 for R-type (funct decides). The ALU selector is 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 set-on-less-than and 1100 NOR.
- R11: When `load_we` is high, `load_data` is written to word `load_addr` of the data array if `load_dmem` is 1, and of the instruction array if it is 0.
- R12: One instruction is committed on every rising clock edge while out of reset. `pc_o` shows the address of the instruction now executing. `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` show the write that the next edge commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Address of the executing instruction |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |

## Verification
The hardest situations to reach are the ones that depend on earlier state: a loop that closes with a backward branch, a store whose effect can only be seen through a later load, and a load whose effective address comes from a negative immediate added to a loaded base. The preloaded program reaches all of them. It includes a counted loop that exits on an equality branch and is re-entered through a jump. It stores a computed value and reads it back, and it loads through a register base with a -1 offset. It also writes to register 0 and then reads that register back. Undefined opcodes and funct codes are placed in the program, along with forward branches both taken and not taken. A behavioural model in the bench steps alongside the core and compares the PC and the write view on every cycle.

// File: rtl/onecycle_cpu.sv
module onecycle_cpu #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [31:0]       load_data,
  output logic [31:0]       pc_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_JUMP  = 6'd2;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;
  localparam logic [3:0] ALU_NOR = 4'b1100;

  logic [31:0] pc;
  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] regs [32];

  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd;
  logic [31:0] simm;

  assign instr = imem[pc[MEM_AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign simm  = {{16{instr[15]}}, instr[15:0]};

  logic reg_dst, branch, mem_read, mem_to_reg, reg_write, mem_write, alu_src, jump;
  logic [1:0] alu_op;

  always_comb begin
    reg_dst = 1'b0; branch = 1'b0; mem_read = 1'b0; mem_to_reg = 1'b0;
    reg_write = 1'b0; mem_write = 1'b0; alu_src = 1'b0; jump = 1'b0;
    alu_op = 2'b00;
    case (op)
      OP_RTYPE: begin reg_dst = 1'b1; reg_write = 1'b1; alu_op = 2'b10; end
      OP_LOAD:  begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; mem_read = 1'b1; end
      OP_STORE: begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ:   begin branch = 1'b1; alu_op = 2'b01; end
      OP_JUMP:  jump = 1'b1;
      default: ;
    endcase
  end

  logic [3:0] alu_ctl;
  logic       funct_ok;

  always_comb begin
    funct_ok = 1'b1;
    case (alu_op)
      2'b00: alu_ctl = ALU_ADD;
      2'b01: alu_ctl = ALU_SUB;
      default: begin
        case (funct)
          6'd32: alu_ctl = ALU_ADD;
          6'd34: alu_ctl = ALU_SUB;
          6'd36: alu_ctl = ALU_AND;
          6'd37: alu_ctl = ALU_OR;
          6'd42: alu_ctl = ALU_SLT;
          default: begin alu_ctl = ALU_ADD; funct_ok = 1'b0; end
        endcase
      end
    endcase
  end

  logic [31:0] a_val, b_reg, b_val, alu_y;
  assign a_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign b_reg = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign b_val = alu_src ? simm : b_reg;

  always_comb begin
    case (alu_ctl)
      ALU_AND: alu_y = a_val & b_val;
      ALU_OR:  alu_y = a_val | b_val;
      ALU_ADD: alu_y = a_val + b_val;
      ALU_SUB: alu_y = a_val - b_val;
      ALU_SLT: alu_y = {31'd0, $signed(a_val) < $signed(b_val)};
      ALU_NOR: alu_y = ~(a_val | b_val);
      default: alu_y = 32'd0;
    endcase
  end

  logic [31:0] rd_word;
  assign rd_word = dmem[alu_y[MEM_AW+1:2]];

  logic [4:0]  waddr;
  logic        wen;
  logic [31:0] wdata;
  assign waddr = reg_dst ? rd : rt;
  assign wen   = reg_write && (alu_op != 2'b10 || funct_ok) && (waddr != 5'd0);
  assign wdata = mem_to_reg ? rd_word : alu_y;

  logic        br_taken;
  logic [31:0] pc_plus4, pc_next;
  assign br_taken = branch && (alu_y == 32'd0);
  assign pc_plus4 = pc + 32'd4;
  assign pc_next  = jump     ? {pc[31:28], instr[25:0], 2'b00} :
                    br_taken ? pc_plus4 + {simm[29:0], 2'b00} : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (wen) regs[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_we && load_dmem) dmem[load_addr] <= load_data;
    else if (mem_write && rst_n) dmem[alu_y[MEM_AW+1:2]] <= b_reg;
  end

  wire unused_read = mem_read;

  assign pc_o       = pc;
  assign rf_we_o    = wen;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wdata;

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc[27:2] == $past(instr[25:0])) && (pc[31:28] == $past(pc[31:28])));

  assert_sequential_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && !branch) |=> pc == $past(pc) + 32'd4);

  assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> !rf_we_o && alu_src);

  assert_branch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    branch |-> !rf_we_o && !mem_write && alu_op == 2'b01);

  assert_load_steering_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |-> mem_to_reg && alu_src && !reg_dst);

  assert_x0_never_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_write && waddr == 5'd0) |-> !rf_we_o);
endmodule

// File: tb/test_onecycle_cpu.sv
module test_onecycle_cpu;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_we = 1'b0, load_dmem = 1'b0;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, rf_wdata_o;
  logic rf_we_o;
  logic [4:0] rf_waddr_o;

  always #2 clk = ~clk;

  onecycle_cpu #(.MEM_AW(MEM_AW)) i_onecycle_cpu (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o));

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at pc=%h: actual %h expected %h", req, what, m_pc, act, exp);
    end
  endtask

  task automatic load(bit dm, int idx, logic [31:0] w);
    load_we = 1'b1; load_dmem = dm; load_addr = MEM_AW'(idx); load_data = w;
    @(negedge clk);
    load_we = 1'b0;
    if (dm) m_dmem[idx] = w; else m_imem[idx] = w;
  endtask

  task automatic step_and_compare();
    logic [31:0] ins, a, b, se, res, addr, nxt;
    logic [5:0] op, fn;
    int rs, rt, rd;
    bit we;
    int wa;
    string tag;
    ins = m_imem[(m_pc >> 2) % DEPTH];
    op = ins[31:26]; fn = ins[5:0];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = m_reg[rs]; b = m_reg[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 4; we = 0; wa = 0; res = 0; tag = "R9";
    if (op == 0) begin
      we = 1; wa = rd; tag = "R2 R10";
      case (fn)
        6'd32: res = a + b;
        6'd34: res = a - b;
        6'd36: res = a & b;
        6'd37: res = a | b;
        6'd42: begin res = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R3"; end
        default: begin we = 0; tag = "R9"; end
      endcase
    end else if (op == 35) begin
      addr = a + se; res = m_dmem[(addr >> 2) % DEPTH]; we = 1; wa = rt; tag = "R4 R11";
    end else if (op == 43) begin
      addr = a + se; m_dmem[(addr >> 2) % DEPTH] = b; tag = "R5";
    end else if (op == 4) begin
      if (a == b) nxt = m_pc + 4 + (se << 2);
      tag = "R6";
    end else if (op == 2) begin
      nxt = {m_pc[31:28], ins[25:0], 2'b00}; tag = "R7";
    end
    if (we && wa == 0) begin we = 0; tag = "R8"; end
    check({tag, " R12"}, "pc", pc_o, m_pc);
    check(tag, "write strobe", 32'(rf_we_o), 32'(we));
    if (we) begin
      check(tag, "write addr", 32'(rf_waddr_o), 32'(wa));
      check(tag, "write data", rf_wdata_o, res);
      m_reg[wa] = res;
    end
    m_pc = nxt;
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_imem[i] = 0; m_dmem[i] = 0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    m_pc = 0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin load(0, i, 32'd0); load(1, i, 32'd0); end
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(1, 3, 32'd1);
    load(1, 4, 32'd3);
    load(0, 0,  rtype(20, 21, 17, 37));
    load(0, 1,  itype(35, 0, 1, 0));
    load(0, 2,  itype(35, 0, 2, 4));
    load(0, 3,  rtype(1, 2, 3, 32));
    load(0, 4,  rtype(1, 2, 4, 34));
    load(0, 5,  rtype(1, 2, 5, 36));
    load(0, 6,  rtype(1, 2, 6, 37));
    load(0, 7,  rtype(2, 1, 7, 42));
    load(0, 8,  rtype(1, 2, 8, 42));
    load(0, 9,  rtype(1, 1, 0, 32));
    load(0, 10, rtype(0, 1, 9, 32));
    load(0, 11, itype(43, 0, 4, 8));
    load(0, 12, itype(35, 0, 10, 8));
    load(0, 13, itype(35, 1, 11, -1));
    load(0, 14, itype(4, 1, 9, 2));
    load(0, 15, rtype(1, 1, 12, 32));
    load(0, 16, rtype(1, 1, 12, 32));
    load(0, 17, itype(4, 1, 2, 5));
    load(0, 18, 32'hFC00_0000);
    load(0, 19, rtype(1, 2, 18, 0));
    load(0, 20, {6'd2, 26'd23});
    load(0, 21, rtype(1, 1, 12, 32));
    load(0, 22, rtype(1, 1, 12, 32));
    load(0, 23, itype(35, 0, 15, 12));
    load(0, 24, itype(35, 0, 16, 16));
    load(0, 25, rtype(14, 15, 14, 32));
    load(0, 26, itype(4, 14, 16, 1));
    load(0, 27, {6'd2, 26'd25});
    load(0, 28, rtype(14, 1, 13, 32));
    load(0, 29, itype(4, 0, 0, -1));
    check("R1", "pc in reset", pc_o, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 60; c++) begin
      step_and_compare();
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule